// File: doc/BRIEF.md
# Parity-Checked Register File

This block is a small synchronous register file in which every word is kept together with one check bit. When a word is written, an XOR reduction network derives the check bit from the data. The data and the check bit are stored side by side. The rule is odd parity: the full stored word, data plus check bit, always holds an odd number of ones.

When a word is read, a second network of the same kind reduces the stored data together with its check bit. The outcome is registered next to the returned data. If any single stored bit has changed since the write, the read returns an error indication. The block only detects errors. It does not correct them, and it does not report which bit went wrong.

Each parity network has an odd-count output and an even-count output. A parameter selects whether the network is built as a balanced XOR tree or as a linear XOR chain. The word width and the address width are also parameters.

Top module: `par_mem`

## Requirements
- R1: After reset, `rdata` and `rerr` are 0, and every address reads back data 0 with `rerr` 0.
- R2: A write (`wr_en` high at a rising clock edge) stores `wdata` at `addr` together with a check bit. The check bit is chosen so that the DW+1 stored bits contain an odd number of ones.
- R3: A read (`rd_en` high at a rising clock edge) presents on `rdata`, after that same edge, the data most recently written to `addr`.
- R4: With the same timing as R3, `rerr` is 1 exactly when the stored data bits and check bit at `addr` hold an even number of ones. An intact word therefore reads with `rerr` 0.
- R5: While `rd_en` is low, `rdata` and `rerr` keep their values, whatever `addr`, `wdata` and `wr_en` do.
- R6: When a read and a write hit the same address at the same edge, the read returns the word held before that write. The new word is returned by the next read.
- R7: If any single stored bit of a word is inverted, whether a data bit or the check bit, the next read of that address gives `rerr` 1. In that read, `rdata` shows the stored data bits as they now are. Other addresses are unaffected, and rewriting the address clears the error.
- R8: The odd output of each parity network equals the XOR of all DW+1 inputs, and the even output is its complement. On write, the top input is held at 0. Tree and chain variants give identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Word address shared by read and write |
| wdata | input | DW | Data to store |
| rdata | output | DW | Data of the last read, valid one cycle after the strobe |
| rerr | output | 1 | Parity error of the last read, same timing as rdata |

## Verification
The assertions check four things on every cycle. Each written word lands in storage with an odd count of ones. Each read returns the selected word's data bits and the complement of its parity. The outputs hold while no read is strobed. Both parity networks agree with a plain reduction XOR. The bench scenarios show what only a sequence of operations can reveal: the contents after reset, the return of previously written patterns, the ordering when a read and a write hit the same address together, and the detection of an inverted stored bit in data or check position followed by recovery after a rewrite.

// File: rtl/par_mem_pkg.sv
package par_mem_pkg;

   typedef enum logic {
      GEN_TREE  = 1'b0,
      GEN_CHAIN = 1'b1
   } gen_arch_e;

   function automatic int pow2_ceil(input int n);
      int p;
      p = 1;
      while (p < n) p = p * 2;
      return p;
   endfunction

endpackage

// File: rtl/par_gen.sv
module par_gen
   import par_mem_pkg::*;
#(
   parameter int        N    = 9,
   parameter gen_arch_e ARCH = GEN_TREE
) (
   input  logic [N-1:0] din,
   output logic         odd_o,
   output logic         even_o
);

   localparam int NP    = pow2_ceil(N);
   localparam int NODES = 2 * NP - 1;

   if (N < 2) begin : g_bad_n
      $error("par_gen: N must be at least 2");
   end

   if (ARCH == GEN_TREE) begin : g_tree
      logic node [NODES];
      for (genvar k = 0; k < NP; k++) begin : g_leaf
         if (k < N) begin : g_used
            assign node[NP - 1 + k] = din[k];
         end else begin : g_pad
            assign node[NP - 1 + k] = 1'b0;
         end
      end
      for (genvar i = 0; i < NP - 1; i++) begin : g_inner
         assign node[i] = node[2 * i + 1] ^ node[2 * i + 2];
      end
      assign odd_o = node[0];
   end else begin : g_chain
      logic [N-1:0] link;
      assign link[0] = din[0];
      for (genvar k = 1; k < N; k++) begin : g_link
         assign link[k] = link[k-1] ^ din[k];
      end
      assign odd_o = link[N-1];
   end

   assign even_o = ~odd_o;

endmodule

// File: rtl/par_store.sv
module par_store #(
   parameter int DW    = 8,
   parameter int AW    = 4,
   parameter int DEPTH = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AW-1:0]         addr,
   input  logic [DW:0]           wword,
   output logic [DW:0]           rword,
   output logic [DEPTH*(DW+1)-1:0] words_flat
);

   localparam int NIN = DW + 1;
   localparam logic [NIN-1:0] CLEAN = NIN'(1) << DW;

   if (DEPTH > (1 << AW)) begin : g_bad_depth
      $error("par_store: DEPTH exceeds address range");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [NIN-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= CLEAN;
         end else if (wr_en && (addr == AW'(i))) begin
            word_q <= wword;
         end
      end
      assign words_flat[i*NIN +: NIN] = word_q;
   end

   assign rword = words_flat[int'(addr) * NIN +: NIN];

endmodule

// File: rtl/par_mem.sv
module par_mem
   import par_mem_pkg::*;
#(
   parameter int        DW   = 8,
   parameter int        AW   = 4,
   parameter gen_arch_e ARCH = GEN_TREE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          rerr
);

   localparam int NIN   = DW + 1;
   localparam int DEPTH = 1 << AW;

   if (DW < 1) begin : g_bad_dw
      $error("par_mem: DW must be at least 1");
   end
   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("par_mem: AW must lie in 1..10");
   end

   logic                    w_odd;
   logic                    w_even;
   logic                    r_odd;
   logic                    r_even;
   logic [NIN-1:0]          wword;
   logic [NIN-1:0]          rword;
   logic [DEPTH*NIN-1:0]    words_flat;

   par_gen #(.N(NIN), .ARCH(ARCH)) u_wgen (
      .din    ({1'b0, wdata}),
      .odd_o  (w_odd),
      .even_o (w_even)
   );

   assign wword = {w_even, wdata};

   par_store #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wword      (wword),
      .rword      (rword),
      .words_flat (words_flat)
   );

   par_gen #(.N(NIN), .ARCH(ARCH)) u_rgen (
      .din    (rword),
      .odd_o  (r_odd),
      .even_o (r_even)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         rerr  <= 1'b0;
      end else if (rd_en) begin
         rdata <= rword[DW-1:0];
         rerr  <= ~r_odd;
      end
   end

endmodule

// File: rtl/par_mem_chk.sv
module par_mem_chk #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic                          rd_en,
   input logic [AW-1:0]                 addr,
   input logic [DW-1:0]                 wdata,
   input logic [DW-1:0]                 rdata,
   input logic                          rerr,
   input logic [(1<<AW)*(DW+1)-1:0]     words_flat,
   input logic                          w_odd,
   input logic                          r_even
);

   localparam int NIN = DW + 1;

   logic [NIN-1:0] sel_word;
   logic [NIN-1:0] last_wr_word;
   logic [AW-1:0]  wa_q;
   logic           wchk_q;

   assign sel_word     = words_flat[int'(addr) * NIN +: NIN];
   assign last_wr_word = words_flat[int'(wa_q) * NIN +: NIN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wa_q   <= '0;
         wchk_q <= 1'b0;
      end else begin
         wa_q   <= addr;
         wchk_q <= wr_en;
      end
   end

   AST_WR_ODD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      wchk_q |-> ($countones(last_wr_word) % 2 == 1)); // R2

   AST_RD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rdata == $past(sel_word[DW-1:0]))); // R3

   AST_RD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rerr == ($countones($past(sel_word)) % 2 == 0))); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> ($stable(rdata) && $stable(rerr))); // R5

   AST_WGEN_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      w_odd == (^wdata)); // R8

   AST_RGEN_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      r_even == ($countones(sel_word) % 2 == 0)); // R8

endmodule

bind par_mem par_mem_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_par_mem.sv
`timescale 1ns/1ps
module sim_par_mem;

   localparam int DW = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rerr;

   int total = 0;
   int bad = 0;
   logic [DW:0] flip_v;

   always #2.5 clk = ~clk;

   par_mem #(.DW(DW), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rerr(rerr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp_d,
                     input logic exp_e, input string req);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      chk({req, " rdata"}, 32'(rdata), 32'(exp_d));
      chk({req, " rerr"}, 32'(rerr), 32'(exp_e));
   endtask

   // Invert one stored bit of address 5 (bit DW is the check bit).
   task automatic flip5(input logic [DW-1:0] d, input int bitpos);
      @(negedge clk);
      flip_v = {~^d, d} ^ ((DW+1)'(1) << bitpos);
      force u0.u_store.g_word[5].word_q = flip_v;
      #1;
      release u0.u_store.g_word[5].word_q;
   endtask

   task automatic t_reset;
      chk("R1 rdata after reset", 32'(rdata), 32'h0);
      chk("R1 rerr after reset", 32'(rerr), 32'h0);
      rd(4'd0, 8'h00, 1'b0, "R1 addr0");
      rd(4'd15, 8'h00, 1'b0, "R1 addr15");
   endtask

   task automatic t_patterns;
      logic [DW-1:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80, 8'h7E};
      for (int i = 0; i < 6; i++) wr(AW'(i + 1), pats[i]);
      for (int i = 0; i < 6; i++) rd(AW'(i + 1), pats[i], 1'b0, "R2 R3 R4 R8 pattern");
   endtask

   task automatic t_hold;
      rd(4'd3, 8'hA5, 1'b0, "R5 setup");
      @(negedge clk);
      addr = 4'd2; wdata = 8'h3C; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; addr = 4'd9;
      @(negedge clk);
      chk("R5 rdata held", 32'(rdata), 32'hA5);
      chk("R5 rerr held", 32'(rerr), 32'h0);
      rd(4'd2, 8'h3C, 1'b0, "R5 write during idle landed");
   endtask

   task automatic t_same_cycle;
      wr(4'd7, 8'h11);
      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b1; addr = 4'd7; wdata = 8'h22;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R6 old word returned", 32'(rdata), 32'h11);
      rd(4'd7, 8'h22, 1'b0, "R6 new word next read");
   endtask

   task automatic t_flip;
      wr(4'd5, 8'h5A);
      wr(4'd6, 8'hC3);
      @(negedge clk);
      flip5(8'h5A, 2);
      rd(4'd5, 8'h5A ^ 8'h04, 1'b1, "R7 data bit flip");
      rd(4'd6, 8'hC3, 1'b0, "R7 neighbour intact");
      wr(4'd5, 8'h5A);
      rd(4'd5, 8'h5A, 1'b0, "R7 rewrite clears");
      @(negedge clk);
      flip5(8'h5A, DW);
      rd(4'd5, 8'h5A, 1'b1, "R7 check bit flip");
      wr(4'd5, 8'hF0);
      @(negedge clk);
      flip5(8'hF0, 7);
      rd(4'd5, 8'h70, 1'b1, "R7 top data bit flip");
   endtask

   initial begin
      #(200000 * 5);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_patterns;
      t_hold;
      t_same_cycle;
      t_flip;
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule